// File: doc/BRIEF.md
# Two-Stage Serial Bus Clock Divider

This block derives a serial bus clock from a fast reference clock. The divide ratio is the product of two programmed factors: an even prescale value and a second-stage factor of one plus a rate value. The prescaler counts reference cycles, and the second stage counts prescaler wraps. The output toggles each time both stages wrap together, so the high and low phases always have the same length. With a 160 MHz reference, the two 8-bit fields cover bus clocks from well below 400 kHz up to 48 MHz and beyond.

Both factors sit in a 32-bit timing register that also holds a 16-bit data-timeout value. That value is not used here and belongs to other logic. The clock fields and the timeout field have separate write strobes, so writing one group never disturbs the other. Software writes new settings at any time. The counters pick them up only at the end of a half period, so the output never shows a short pulse. The block also provides a strobe that is high in the reference cycle just before each output edge, so the shift logic can prepare data one cycle ahead.

Top module: `serclk_div`

## Requirements
- R1: The output is free-running with period D*(1+R) reference cycles, where D is the effective divide value and R is the rate field. The high and low phases are each D*(1+R)/2 cycles long.
- R2: Bit 0 of the divide field is ignored, so a programmed 7 behaves as 6.
- R3: A divide field below 2 (0 or 1) behaves as 2.
- R4: The rate field spans 0 to 255, giving a second-stage factor of 1 to 256. Rate 255 with divide 2 gives 256-cycle phases.
- R5: New settings take effect only at a half-period boundary. After a write, the phase already in progress completes with its old length, and every following phase uses the new length.
- R6: `edge_o` is high in exactly those reference cycles after which `sclk_o` changes level.
- R7: While `rst_ni` is low, `sclk_o` is low. After reset, `timing_o` reads 0x0200_0000 (divide 2, rate 0, timeout 0).
- R8: Field layout of the timing register: timeout in bits [15:0], rate in bits [23:16], divide in bits [31:24]. `wr_clk_i` writes only the divide and rate fields. `wr_tmo_i` writes only the timeout field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_clk_i | input | 1 | Write strobe for the divide and rate fields |
| wr_tmo_i | input | 1 | Write strobe for the timeout field |
| wdata_i | input | 32 | Write data in the timing register layout |
| timing_o | output | 32 | Current timing register contents |
| sclk_o | output | 1 | Divided serial clock |
| edge_o | output | 1 | High one reference cycle before each sclk_o edge |

## Verification
A counter that runs past its terminal value, or a stale active setting, shows up at once as a phase of wrong length on `sclk_o`. The bench sees this within one output period, because it measures the high and low phases separately. A load at the wrong moment shows up as a shortened phase right after a write. The bench therefore times each phase across a reprogramming. A strobe that is out of step with the toggle register shows as a mismatch in the very next cycle. Register write-masking faults show on `timing_o` one cycle after the strobe.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int DIV_W  = 8;
  localparam int RATE_W = 8;
  localparam int TMO_W  = 16;
  localparam int HALF_W = DIV_W - 1;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [RATE_W-1:0] rate;
    logic [TMO_W-1:0]  tmo;
  } timing_t;

  localparam int REG_W = $bits(timing_t);

  // half of the even prescale, bit 0 dropped, floor of 1
  function automatic logic [HALF_W-1:0] eff_half(input logic [DIV_W-1:0] d);
    logic [HALF_W-1:0] h;
    h = d[DIV_W-1:1];
    if (h == '0) h = HALF_W'(1);
    return h;
  endfunction
endpackage

// File: rtl/serclk_timing_reg.sv
module serclk_timing_reg
  import serclk_pkg::*;
#(
  parameter logic [DIV_W-1:0]  DIV_RST  = DIV_W'(2),
  parameter logic [RATE_W-1:0] RATE_RST = '0,
  parameter logic [TMO_W-1:0]  TMO_RST  = '0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_clk_i,
  input  logic    wr_tmo_i,
  input  timing_t wdata_i,
  output timing_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o.div  <= DIV_RST;
      q_o.rate <= RATE_RST;
      q_o.tmo  <= TMO_RST;
    end else begin
      if (wr_clk_i) begin
        q_o.div  <= wdata_i.div;
        q_o.rate <= wdata_i.rate;
      end
      if (wr_tmo_i) q_o.tmo <= wdata_i.tmo;
    end
  end

  p_tmo_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tmo_i |=> $stable(q_o.tmo));
  p_clk_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clk_i |=> ($stable(q_o.div) && $stable(q_o.rate)));
endmodule

// File: rtl/serclk_stage.sv
module serclk_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/serclk_div.sv
module serclk_div
  import serclk_pkg::*;
#(
  parameter logic [DIV_W-1:0]  DIV_RST  = DIV_W'(2),
  parameter logic [RATE_W-1:0] RATE_RST = '0,
  parameter logic [TMO_W-1:0]  TMO_RST  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_clk_i,
  input  logic             wr_tmo_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] timing_o,
  output logic             sclk_o,
  output logic             edge_o
);
  timing_t           cfg;
  logic [HALF_W-1:0] act_pre_q;
  logic [RATE_W-1:0] act_rate_q;
  logic              sclk_q;
  logic              pre_wrap;
  logic              half_done;

  serclk_timing_reg #(
    .DIV_RST (DIV_RST),
    .RATE_RST(RATE_RST),
    .TMO_RST (TMO_RST)
  ) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_clk_i(wr_clk_i),
    .wr_tmo_i(wr_tmo_i),
    .wdata_i (timing_t'(wdata_i)),
    .q_o     (cfg)
  );

  serclk_stage #(.W(HALF_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (1'b1),
    .last_i(act_pre_q),
    .wrap_o(pre_wrap)
  );

  serclk_stage #(.W(RATE_W)) u_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pre_wrap),
    .last_i(act_rate_q),
    .wrap_o(half_done)
  );

  // settings move into the counters only when both stages wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pre_q  <= eff_half(DIV_RST) - 1'b1;
      act_rate_q <= RATE_RST;
      sclk_q     <= 1'b0;
    end else if (half_done) begin
      act_pre_q  <= eff_half(cfg.div) - 1'b1;
      act_rate_q <= cfg.rate;
      sclk_q     <= ~sclk_q;
    end
  end

  assign timing_o = cfg;
  assign sclk_o   = sclk_q;
  assign edge_o   = half_done;

  p_toggle_on_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (sclk_o != $past(sclk_o)));
  p_hold_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_o |=> $stable(sclk_o));
  p_settings_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_o |=> ($stable(act_pre_q) && $stable(act_rate_q)));
  always @(posedge clk_i) begin
    if (!rst_ni) p_low_in_reset_r7: assert (!sclk_o);
  end
endmodule

// File: tb/serclk_div_tb.sv
module serclk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_clk_i = 1'b0;
  logic        wr_tmo_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] timing_o;
  logic        sclk_o;
  logic        edge_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  serclk_div u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_clk_i(wr_clk_i),
    .wr_tmo_i(wr_tmo_i),
    .wdata_i (wdata_i),
    .timing_o(timing_o),
    .sclk_o  (sclk_o),
    .edge_o  (edge_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WDOG_CYC) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG_CYC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic c, input logic t, input logic [31:0] d);
    @(negedge clk_i);
    wr_clk_i = c;
    wr_tmo_i = t;
    wdata_i  = d;
    @(negedge clk_i);
    wr_clk_i = 1'b0;
    wr_tmo_i = 1'b0;
  endtask

  // cycles until sclk_o leaves its current level
  task automatic next_change(output int n);
    logic lvl;
    lvl = sclk_o;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (sclk_o == lvl && n < 2000);
  endtask

  task automatic wait_rise();
    int n;
    do next_change(n); while (sclk_o != 1'b1);
  endtask

  task automatic prog(input logic [7:0] d, input logic [7:0] r);
    wr(1'b1, 1'b0, {d, r, 16'h0});
    wait_rise();
    wait_rise();
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(sclk_o == 1'b0, "R7 sclk low in reset", sclk_o, 0);
    chk(timing_o == 32'h0200_0000, "R7 reset register", timing_o, 32'h0200_0000);
  endtask

  task automatic t_period(input logic [7:0] d, input logic [7:0] r, input int half, input string tag);
    int hi, lo;
    prog(d, r);
    next_change(hi);
    next_change(lo);
    chk(hi == half, {tag, " high phase"}, hi, half);
    chk(lo == half, {tag, " low phase"}, lo, half);
  endtask

  task automatic t_fields();
    logic [7:0] d0, r0;
    d0 = timing_o[31:24];
    r0 = timing_o[23:16];
    wr(1'b0, 1'b1, {16'hFFFF, 16'hBEEF});
    chk(timing_o == {d0, r0, 16'hBEEF}, "R8 timeout write keeps clock fields",
        timing_o, {d0, r0, 16'hBEEF});
    wr(1'b1, 1'b0, {8'd10, 8'd1, 16'h1234});
    chk(timing_o == {8'd10, 8'd1, 16'hBEEF}, "R8 clock write keeps timeout",
        timing_o, {8'd10, 8'd1, 16'hBEEF});
  endtask

  task automatic t_switch();
    int n;
    bit ok;
    prog(8'd6, 8'd3);
    wait_rise();
    wr(1'b1, 1'b0, {8'd2, 8'd0, 16'h0});
    next_change(n);
    chk(n == 10, "R5 phase in progress keeps old length", n, 10);
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      next_change(n);
      if (n != 1) ok = 1'b0;
    end
    chk(ok, "R5 later phases use new length", ok, 1);
  endtask

  task automatic t_strobe(input logic [7:0] d, input logic [7:0] r);
    int bad;
    logic e, s;
    prog(d, r);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      e = edge_o;
      s = sclk_o;
      @(negedge clk_i);
      if ((sclk_o != s) != e) bad++;
    end
    chk(bad == 0, "R6 strobe precedes every edge", bad, 0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_period(8'd2,   8'd0,   1,   "R1 div2 rate0");
    t_period(8'd6,   8'd3,   12,  "R1 div6 rate3");
    t_period(8'd254, 8'd1,   254, "R1 div254 rate1");
    t_period(8'd7,   8'd2,   9,   "R2 odd divide");
    t_period(8'd1,   8'd0,   1,   "R3 divide 1");
    t_period(8'd0,   8'd4,   5,   "R3 divide 0");
    t_period(8'd2,   8'd255, 256, "R4 rate 255");
    t_fields();
    t_switch();
    t_strobe(8'd2, 8'd0);
    t_strobe(8'd8, 8'd2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule